// File: doc/BRIEF.md
# UART Transmit Status Flags

This block keeps the transmit-side status of a UART. It counts the characters waiting to be sent and produces three outputs: a "holding empty" flag that tells the host it may write again, a "transmitter empty" flag that tells the host the line has gone quiet, and a registered interrupt request. The character store itself and the serial shifter are outside the block. The block sees the store as an occupancy count, and it sees the shifter only through a load strobe and an idle indication.

Two storage modes are supported. With the FIFO disabled, a single holding register is modelled and its capacity is one character. With the FIFO enabled, the capacity is `DEPTH` characters, 32 by default. A change of mode empties the store. The holding-empty flag is registered from the next occupancy, so it changes at the same clock edge as the write or the move that causes the change. The interrupt request is that flag ANDed with an enable and registered once more.

Top module: `txstat_top`

## Requirements
- R1: After reset, thrEmpty=1, txEmpty=1, txIrq=0 and txLevel=0.
- R2: A host write that is accepted raises txLevel by one and drives thrEmpty to 0 at the clock edge that samples the write.
- R3: With fifoEn=0 the capacity is one character. A write while txLevel=1 is dropped. A shiftLoad while txLevel=1 returns txLevel to 0 and sets thrEmpty at that edge.
- R4: With fifoEn=1, txLevel may reach DEPTH. After every edge, thrEmpty=1 exactly when txLevel=0.
- R5: After every edge, txEmpty=1 exactly when the new txLevel is 0, shiftIdle was 1 and no byte was moved by shiftLoad in that cycle. txEmpty=1 always implies thrEmpty=1.
- R6: txIrq equals the thrEmpty value before an edge ANDed with intEn, registered at that edge. It therefore lags thrEmpty by one cycle.
- R7: A shiftLoad while txLevel=0 is ignored, so txLevel stays 0.
- R8: A host write when txLevel equals the capacity is dropped, even when a shiftLoad occurs in the same cycle. With fifoEn=1, txLevel never exceeds DEPTH.
- R9: In a cycle where fifoEn differs from its value in the previous cycle (taken as 0 during reset), txLevel goes to 0. Writes and loads in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host writes one character |
| shiftLoad | input | 1 | Shifter takes one character |
| shiftIdle | input | 1 | Shifter has nothing to send |
| fifoEn | input | 1 | 1 selects FIFO mode, 0 selects the single holding register |
| intEn | input | 1 | Transmit-ready interrupt enable |
| thrEmpty | output | 1 | No character is waiting |
| txEmpty | output | 1 | Store and shifter are both empty |
| txIrq | output | 1 | Registered transmit-ready interrupt request |
| txLevel | output | $clog2(DEPTH+1) | Characters waiting |

## Verification
txLevel, thrEmpty and txEmpty are due at the first rising edge after the inputs that cause them. txIrq is due one edge later, because it is registered from the flag. The bench drives inputs on the falling edge and advances its reference state once per rising edge. It compares all four outputs at the following falling edge, so every result is sampled exactly one edge after its cause, and txIrq is compared against the flag value from before that edge. Directed sequences cover filling the FIFO to capacity, a write while full, a load while empty, and a mode change while the store holds characters.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } txStrobe_t;
endpackage

// File: rtl/txstat_ctrl.sv
module txstat_ctrl
  import txstat_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWr,
  input  logic          shiftLoad,
  input  logic          fifoEn,
  input  logic [CW-1:0] level,
  output txStrobe_t     strobe
);
  localparam logic [CW-1:0] FULL_FIFO = CW'(DEPTH);
  localparam logic [CW-1:0] FULL_ONE  = CW'(1);

  logic          fifoEnQ;
  logic [CW-1:0] capacity;
  logic          atCapacity;

  always_ff @(posedge clk) begin
    if (!rstN) fifoEnQ <= 1'b0;
    else       fifoEnQ <= fifoEn;
  end

  assign capacity   = fifoEn ? FULL_FIFO : FULL_ONE;
  assign atCapacity = (level >= capacity);

  always_comb begin
    strobe.flush = (fifoEn != fifoEnQ);
    strobe.push  = hostWr && !atCapacity && !strobe.flush;
    strobe.pop   = shiftLoad && (level != '0) && !strobe.flush;
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && fifoEnQ && level == FULL_FIFO && hostWr && !shiftLoad) |=> (level == FULL_FIFO)); // R8

  AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && !fifoEnQ && level == FULL_ONE && hostWr && !shiftLoad) |=> (level == FULL_ONE)); // R3
endmodule

// File: rtl/txstat_dp.sv
module txstat_dp
  import txstat_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  txStrobe_t     strobe,
  input  logic          shiftIdle,
  input  logic          intEn,
  output logic [CW-1:0] level,
  output logic          thrEmpty,
  output logic          txEmpty,
  output logic          txIrq
);
  logic [CW-1:0] levelNext;

  always_comb begin
    levelNext = level;
    if (strobe.flush)
      levelNext = '0;
    else if (strobe.push && !strobe.pop)
      levelNext = level + CW'(1);
    else if (strobe.pop && !strobe.push)
      levelNext = level - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level    <= '0;
      thrEmpty <= 1'b1;
      txEmpty  <= 1'b1;
      txIrq    <= 1'b0;
    end else begin
      level    <= levelNext;
      thrEmpty <= (levelNext == '0);
      txEmpty  <= (levelNext == '0) && shiftIdle && !strobe.pop;
      txIrq    <= thrEmpty && intEn;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= CW'(DEPTH)); // R8

  AST_PUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> !thrEmpty); // R2

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (level == '0 && thrEmpty)); // R9

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (thrEmpty && intEn) |=> txIrq); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !intEn |=> !txIrq); // R6

  AST_TXE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> thrEmpty); // R5
endmodule

// File: rtl/txstat_top.sv
module txstat_top
  import txstat_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWr,
  input  logic          shiftLoad,
  input  logic          shiftIdle,
  input  logic          fifoEn,
  input  logic          intEn,
  output logic          thrEmpty,
  output logic          txEmpty,
  output logic          txIrq,
  output logic [CW-1:0] txLevel
);
  txStrobe_t strobe;

  txstat_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .shiftLoad(shiftLoad),
    .fifoEn(fifoEn), .level(txLevel), .strobe(strobe)
  );

  txstat_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .shiftIdle(shiftIdle),
    .intEn(intEn), .level(txLevel), .thrEmpty(thrEmpty),
    .txEmpty(txEmpty), .txIrq(txIrq)
  );
endmodule

// File: tb/txstat_top_test.sv
`timescale 1ns/1ps
module txstat_top_test;
  localparam int DEPTH = 32;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWr = 0, shiftLoad = 0, shiftIdle = 1, fifoEn = 0, intEn = 0;
  logic thrEmpty, txEmpty, txIrq;
  logic [CW-1:0] txLevel;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  int  mLevel = 0;
  bit  mThr = 1, mTxe = 1, mIrq = 0, mFifoPrev = 0;

  always #4 clk = ~clk;

  txstat_top #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .shiftLoad(shiftLoad),
    .shiftIdle(shiftIdle), .fifoEn(fifoEn), .intEn(intEn),
    .thrEmpty(thrEmpty), .txEmpty(txEmpty), .txIrq(txIrq), .txLevel(txLevel)
  );

  function automatic int capOf(bit fe);
    return fe ? DEPTH : 1;
  endfunction

  task automatic check(string req, string what, int got, int exp);
    testsRun++;
    if (got != exp) begin
      testsFailed++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // One clock: advance the reference, then compare at the falling edge.
  task automatic cycle();
    bit flush, push, pop;
    int nLevel;
    flush = (fifoEn != mFifoPrev);
    push  = hostWr && (mLevel < capOf(fifoEn)) && !flush;
    pop   = shiftLoad && (mLevel != 0) && !flush;
    nLevel = flush ? 0 : mLevel + int'(push) - int'(pop);
    @(posedge clk);
    mIrq = mThr && intEn;
    mThr = (nLevel == 0);
    mTxe = (nLevel == 0) && shiftIdle && !pop;
    mLevel = nLevel;
    mFifoPrev = fifoEn;
    @(negedge clk);
    check(fifoEn ? "R4" : "R3", "txLevel", int'(txLevel), mLevel);
    check(fifoEn ? "R4" : "R3", "thrEmpty", int'(thrEmpty), int'(mThr));
    check("R5", "txEmpty", int'(txEmpty), int'(mTxe));
    check("R6", "txIrq", int'(txIrq), int'(mIrq));
  endtask

  task automatic drive(bit w, bit l, bit idle, bit fe, bit ie);
    hostWr = w; shiftLoad = l; shiftIdle = idle; fifoEn = fe; intEn = ie;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "thrEmpty", int'(thrEmpty), 1);
    check("R1", "txEmpty", int'(txEmpty), 1);
    check("R1", "txIrq", int'(txIrq), 0);
    check("R1", "txLevel", int'(txLevel), 0);
    rstN = 1'b1;

    // R2 single-mode write clears thrEmpty at that edge
    drive(1, 0, 1, 0, 1); cycle();
    check("R2", "thrEmpty after write", int'(thrEmpty), 0);
    check("R2", "txLevel after write", int'(txLevel), 1);
    // R3 second write dropped
    drive(1, 0, 1, 0, 1); cycle();
    check("R3", "txLevel after drop", int'(txLevel), 1);
    // R6 irq falls one cycle after flag
    check("R6", "txIrq lag", int'(txIrq), 0);
    // R3 load empties holding register
    drive(0, 1, 1, 0, 1); cycle();
    check("R3", "thrEmpty after load", int'(thrEmpty), 1);
    check("R5", "txEmpty while loading", int'(txEmpty), 0);
    drive(0, 0, 1, 0, 1); cycle();
    check("R6", "txIrq rises one edge later", int'(txIrq), 1);
    // R7 load while empty ignored
    drive(0, 1, 1, 0, 1); cycle();
    check("R7", "txLevel after empty load", int'(txLevel), 0);

    // R9 enter FIFO mode with a pending write: dropped
    drive(1, 0, 0, 1, 1); cycle();
    check("R9", "txLevel on mode change", int'(txLevel), 0);
    // R8 fill and overfill
    for (int i = 0; i < DEPTH + 3; i++) begin
      drive(1, 0, 0, 1, 1); cycle();
    end
    check("R8", "txLevel at full", int'(txLevel), DEPTH);
    drive(1, 1, 0, 1, 1); cycle();
    check("R8", "write with load at full", int'(txLevel), DEPTH - 1);
    check("R4", "thrEmpty while holding", int'(thrEmpty), 0);
    // R9 leave FIFO mode flushes
    drive(0, 1, 1, 0, 1); cycle();
    check("R9", "txLevel after flush", int'(txLevel), 0);
    check("R9", "thrEmpty after flush", int'(thrEmpty), 1);

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      bit fe;
      fe = (($urandom % 200) == 0) ? !fifoEn : fifoEn;
      drive(($urandom % 3) != 0, ($urandom % 3) == 0, ($urandom % 2) == 0,
            fe, ($urandom % 5) != 0);
      cycle();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule